// File: doc/BRIEF.md
# PCI DMA Window Address Translator

This block converts inbound bus-master DMA addresses into system memory addresses. It has four programmable windows. Each window holds a base/enable word, a size mask and a translated base. A window maps a hit in one of two ways. In direct mode it returns a physical base and an offset mask. In scatter-gather mode it builds the address of an 8-byte page table entry and fetches that entry from system memory over a 64-bit read port. Addresses wider than 32 bits take separate paths: a pass-through range that can be switched on, and a page-table path that only the last window serves.

Requests enter on a valid/ready port and are handled one at a time. A result leaves on a valid/ready port as a hit flag, a translated base and an offset mask. The physical address is `rsp_addr | (pci_address & rsp_mask)`. The request port is ready only while the block is idle. A result is held unchanged until `rsp_ready` is sampled high. A memory read request is held, with a stable address, until `mrd_ready` is sampled high. The read response is taken in any cycle where `mrd_rvalid` and `mrd_rready` are both high. Only one table read is outstanding at a time. Software-side configuration goes through a plain write strobe with a select code.

Top module: `pci_dma_xlate`

## Requirements
- R1: After reset, `req_ready` is 1 and `rsp_valid`, `mrd_valid` and `mrd_rready` are 0. Windows 0 to 2 are disabled. The last window is disabled and has its table-mode bit set.
- R2: A write to `cfg_sel = {group[1:0], index[1:0]}` stores `cfg_wdata` with masking, as follows.
  - Group 0 is the window base. Windows 0 to 2 keep bits 31:20 (base), bit 1 (table mode) and bit 0 (enable). Window 3 keeps bits 39 (wide-cycle enable), 31:20 and 0, and its bit 1 is always 1.
  - Group 1 is the size mask and keeps bits 31:20.
  - Group 2 is the translated base and keeps bits 34:10.
  - Group 3 with index 0 is control. Bit 5 enables the hole and bit 6 enables pass-through.
- R3: Let ext = mask | 0xFFFFF. A window hits an address below 2^32 when its enable bit is 1 and (addr & ~ext) equals base & 0xFFF00000.
- R4: For addresses below 2^32, windows are tried in the order 0, 1, 2, 3 and the first hit wins. Window 3 is never tried when its bit 39 is set.
- R5: A direct hit (bit 1 = 0) returns hit = 1, rsp_addr = tba & ~ext and rsp_mask = ext.
- R6: A table-mode hit reads memory at (tba & ~(mask >> 10)) | ((addr & (mask | 0xFE000)) >> 10). This address is always 8-byte aligned.
- R7: A fetched entry with bit 0 = 1 returns hit = 1, rsp_addr = (entry & 0x3FFFFE) << 12 and rsp_mask = 0x1FFF. An entry with bit 0 = 0 is a miss.
- R8: With control bit 5 set, addresses 0x80000 to 0xFFFFF miss without any memory read.
- R9: An address in [2^40, 2^41) returns hit = 1, rsp_addr = 0 and rsp_mask = 0x7_FFFF_FFFF when control bit 6 is set. Otherwise it misses.
- R10: An address in [2^43, 2^44) reads memory at (tba3 & 0x7_FFC0_0000) | ((addr & 0xFFFF_E000) >> 10) when window 3 has both bit 0 and bit 39 set. Any other wide address misses.
- R11: A miss returns hit = 0, rsp_addr = 0 and rsp_mask = 0.
- R12: The handshake rules are as follows.
  - `req_ready` is high only when no request is in flight.
  - The result stays stable while it is stalled.
  - The read request stays stable until it is accepted.
  - Only one read is outstanding at a time.
- R13: A request that needs no memory read has `rsp_valid` high in the second cycle after the cycle it was accepted in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 4 | Configuration select {group, index} |
| cfg_wdata | input | 64 | Configuration write data |
| req_valid | input | 1 | DMA address valid |
| req_ready | output | 1 | Block idle, accepts an address |
| req_addr | input | 64 | DMA address to translate |
| rsp_valid | output | 1 | Result valid |
| rsp_ready | input | 1 | Result accepted |
| rsp_hit | output | 1 | Translation succeeded |
| rsp_addr | output | 64 | Translated base |
| rsp_mask | output | 64 | Offset mask |
| mrd_valid | output | 1 | Table read request valid |
| mrd_ready | input | 1 | Table read request accepted |
| mrd_addr | output | 64 | Table entry address |
| mrd_rvalid | input | 1 | Table read data valid |
| mrd_rready | output | 1 | Block waits for table data |
| mrd_rdata | input | 64 | Table entry |

## Verification
The assertions assume the configuration is not written while a request is in flight, because the decode reads the window registers live. They also assume `mrd_rvalid` is raised only after a read request has been accepted. The stimulus writes the windows only between transactions. The memory model answers only after it has seen a read accepted, with a random delay, while `mrd_ready` and `rsp_ready` are randomly withheld so that both stall paths are exercised. Window layouts are directed to cover overlap priority, the hole edges, the wide-cycle skip and invalid entries, and then randomized, with addresses biased toward the programmed bases.

// File: rtl/dmx_pkg.sv
package dmx_pkg;
  localparam int DW = 64;

  // Register field keep masks
  localparam logic [DW-1:0] BASE_KEEP      = 64'h0000_0000_fff0_0003;
  localparam logic [DW-1:0] LAST_BASE_KEEP = 64'h0000_0080_fff0_0001;
  localparam logic [DW-1:0] SG_BIT         = 64'h2;
  localparam int            DAC_POS        = 39;
  localparam logic [DW-1:0] MASK_KEEP      = 64'h0000_0000_fff0_0000;
  localparam logic [DW-1:0] TBA_KEEP       = 64'h0000_0007_ffff_fc00;
  localparam int            HOLE_POS       = 5;
  localparam int            PASS_POS       = 6;

  // Translation constants
  localparam logic [DW-1:0] GRAIN          = 64'h0000_0000_000f_ffff;
  localparam logic [DW-1:0] SG_IDX_KEEP    = 64'h0000_0000_000f_e000;
  localparam int            ENTRY_SHIFT    = 10;
  localparam logic [DW-1:0] FRAME_KEEP     = 64'h0000_0000_003f_fffe;
  localparam int            FRAME_SHIFT    = 12;
  localparam logic [DW-1:0] PAGE_OFS       = 64'h0000_0000_0000_1fff;
  localparam logic [DW-1:0] PASS_OFS       = 64'h0000_0007_ffff_ffff;
  localparam logic [DW-1:0] WIDE_TBA_KEEP  = 64'h0000_0007_ffc0_0000;
  localparam logic [DW-1:0] WIDE_IDX_KEEP  = 64'h0000_0000_ffff_e000;
  localparam logic [DW-1:0] HOLE_LO        = 64'h0000_0000_0008_0000;
  localparam logic [DW-1:0] HOLE_HI        = 64'h0000_0000_000f_ffff;

  // Configuration groups
  localparam logic [1:0] GRP_BASE = 2'd0;
  localparam logic [1:0] GRP_MASK = 2'd1;
  localparam logic [1:0] GRP_TBA  = 2'd2;
  localparam logic [1:0] GRP_CTL  = 2'd3;

  typedef enum logic [1:0] {XK_MISS, XK_DIRECT, XK_FETCH} xkind_e;
  typedef enum logic [2:0] {ST_IDLE, ST_DEC, ST_FETCH, ST_WAIT, ST_RESP} xstate_e;
endpackage

// File: rtl/dmx_regs.sv
module dmx_regs
  import dmx_pkg::*;
#(
  parameter int NWIN = 4,
  localparam int IW = $clog2(NWIN),
  localparam int SW = IW + 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cfg_we,
  input  logic [SW-1:0]            cfg_sel,
  input  logic [DW-1:0]            cfg_wdata,
  output logic [NWIN-1:0][DW-1:0]  win_base,
  output logic [NWIN-1:0][DW-1:0]  win_mask,
  output logic [NWIN-1:0][DW-1:0]  win_tba,
  output logic                     hole_en,
  output logic                     pass_en
);
  logic [1:0]    grp;
  logic [IW-1:0] idx;

  assign grp = cfg_sel[SW-1 -: 2];
  assign idx = cfg_sel[IW-1:0];

  for (genvar i = 0; i < NWIN; i++) begin : g_win
    localparam logic [DW-1:0] RST_BASE = (i == NWIN - 1) ? SG_BIT : '0;
    logic hit_sel;
    assign hit_sel = cfg_we && (idx == IW'(i));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        win_base[i] <= RST_BASE;
        win_mask[i] <= '0;
        win_tba[i]  <= '0;
      end else if (hit_sel) begin
        if (grp == GRP_BASE) begin
          if (i == NWIN - 1) win_base[i] <= (cfg_wdata & LAST_BASE_KEEP) | SG_BIT;
          else               win_base[i] <= cfg_wdata & BASE_KEEP;
        end
        if (grp == GRP_MASK) win_mask[i] <= cfg_wdata & MASK_KEEP;
        if (grp == GRP_TBA)  win_tba[i]  <= cfg_wdata & TBA_KEEP;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hole_en <= 1'b0;
      pass_en <= 1'b0;
    end else if (cfg_we && grp == GRP_CTL && idx == '0) begin
      hole_en <= cfg_wdata[HOLE_POS];
      pass_en <= cfg_wdata[PASS_POS];
    end
  end

  // R2: the last window keeps table mode and drops bits above 39 after any base write
  assert_last_sg_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && grp == GRP_BASE && idx == IW'(NWIN - 1))
      |=> (win_base[NWIN-1][1] && win_base[NWIN-1][DW-1:DAC_POS+1] == '0));

  // R2: the lower windows never hold bits outside their keep mask after a write
  assert_base_keep_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && grp == GRP_BASE && idx == '0)
      |=> ((win_base[0] & ~BASE_KEEP) == '0));
endmodule

// File: rtl/dmx_window.sv
module dmx_window
  import dmx_pkg::*;
(
  input  logic [DW-1:0] addr,
  input  logic [DW-1:0] base,
  input  logic [DW-1:0] mask,
  input  logic [DW-1:0] tba,
  output logic          hit,
  output logic          sg,
  output logic [DW-1:0] map_base,
  output logic [DW-1:0] map_mask,
  output logic [DW-1:0] entry_addr
);
  logic [DW-1:0] ext;

  assign ext        = mask | GRAIN;
  assign hit        = base[0] && ((addr & ~ext) == (base & MASK_KEEP));
  assign sg         = base[1];
  assign map_base   = tba & ~ext;
  assign map_mask   = ext;
  assign entry_addr = (tba & ~(mask >> ENTRY_SHIFT))
                    | ((addr & (mask | SG_IDX_KEEP)) >> ENTRY_SHIFT);
endmodule

// File: rtl/dmx_decode.sv
module dmx_decode
  import dmx_pkg::*;
#(
  parameter int NWIN = 4,
  localparam int IW = $clog2(NWIN)
) (
  input  logic [DW-1:0]            addr,
  input  logic [NWIN-1:0][DW-1:0]  win_base,
  input  logic [NWIN-1:0][DW-1:0]  win_mask,
  input  logic [NWIN-1:0][DW-1:0]  win_tba,
  input  logic                     hole_en,
  input  logic                     pass_en,
  output xkind_e                   kind,
  output logic [DW-1:0]            res_base,
  output logic [DW-1:0]            res_mask,
  output logic [DW-1:0]            entry_addr
);
  localparam int LAST = NWIN - 1;

  logic [NWIN-1:0]          hit, sg, elig;
  logic [NWIN-1:0][DW-1:0]  mbase, mmask, eaddr;
  logic [IW-1:0]            pick;
  logic                     any, narrow, in_hole, in_pass, in_wide, wide_on;

  for (genvar i = 0; i < NWIN; i++) begin : g_w
    dmx_window u_win (
      .addr       (addr),
      .base       (win_base[i]),
      .mask       (win_mask[i]),
      .tba        (win_tba[i]),
      .hit        (hit[i]),
      .sg         (sg[i]),
      .map_base   (mbase[i]),
      .map_mask   (mmask[i]),
      .entry_addr (eaddr[i])
    );
    if (i == LAST) begin : g_last
      assign elig[i] = hit[i] && !win_base[i][DAC_POS];
    end else begin : g_low
      assign elig[i] = hit[i];
    end
  end

  assign narrow  = (addr[DW-1:32] == '0);
  assign in_hole = (addr >= HOLE_LO) && (addr <= HOLE_HI);
  assign in_pass = (addr[DW-1:41] == '0) && addr[40];
  assign in_wide = (addr[DW-1:44] == '0) && addr[43];
  assign wide_on = win_base[LAST][0] && win_base[LAST][DAC_POS];
  assign any     = |elig;

  always_comb begin
    pick = '0;
    for (int i = NWIN - 1; i >= 0; i--) begin
      if (elig[i]) pick = IW'(i);
    end
  end

  always_comb begin
    kind       = XK_MISS;
    res_base   = '0;
    res_mask   = '0;
    entry_addr = '0;
    if (narrow) begin
      if (!(hole_en && in_hole) && any) begin
        if (sg[pick]) begin
          kind       = XK_FETCH;
          entry_addr = eaddr[pick];
        end else begin
          kind     = XK_DIRECT;
          res_base = mbase[pick];
          res_mask = mmask[pick];
        end
      end
    end else if (in_pass) begin
      if (pass_en) begin
        kind     = XK_DIRECT;
        res_mask = PASS_OFS;
      end
    end else if (in_wide && wide_on) begin
      kind       = XK_FETCH;
      entry_addr = (win_tba[LAST] & WIDE_TBA_KEEP)
                 | ((addr & WIDE_IDX_KEEP) >> ENTRY_SHIFT);
    end
  end
endmodule

// File: rtl/pci_dma_xlate.sv
module pci_dma_xlate
  import dmx_pkg::*;
#(
  parameter int NWIN = 4,
  localparam int IW = $clog2(NWIN),
  localparam int SW = IW + 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [SW-1:0] cfg_sel,
  input  logic [DW-1:0] cfg_wdata,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [DW-1:0] req_addr,
  output logic          rsp_valid,
  input  logic          rsp_ready,
  output logic          rsp_hit,
  output logic [DW-1:0] rsp_addr,
  output logic [DW-1:0] rsp_mask,
  output logic          mrd_valid,
  input  logic          mrd_ready,
  output logic [DW-1:0] mrd_addr,
  input  logic          mrd_rvalid,
  output logic          mrd_rready,
  input  logic [DW-1:0] mrd_rdata
);
  logic [NWIN-1:0][DW-1:0] win_base, win_mask, win_tba;
  logic                    hole_en, pass_en;
  xkind_e                  dec_kind;
  logic [DW-1:0]           dec_base, dec_mask, dec_entry;
  xstate_e                 state_q;
  logic [DW-1:0]           addr_q, mrd_addr_q;
  logic                    hit_q;
  logic [DW-1:0]           raddr_q, rmask_q;

  dmx_regs #(.NWIN(NWIN)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_sel   (cfg_sel),
    .cfg_wdata (cfg_wdata),
    .win_base  (win_base),
    .win_mask  (win_mask),
    .win_tba   (win_tba),
    .hole_en   (hole_en),
    .pass_en   (pass_en)
  );

  dmx_decode #(.NWIN(NWIN)) u_dec (
    .addr       (addr_q),
    .win_base   (win_base),
    .win_mask   (win_mask),
    .win_tba    (win_tba),
    .hole_en    (hole_en),
    .pass_en    (pass_en),
    .kind       (dec_kind),
    .res_base   (dec_base),
    .res_mask   (dec_mask),
    .entry_addr (dec_entry)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      addr_q     <= '0;
      mrd_addr_q <= '0;
      hit_q      <= 1'b0;
      raddr_q    <= '0;
      rmask_q    <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (req_valid) begin
          addr_q  <= req_addr;
          state_q <= ST_DEC;
        end
        ST_DEC: begin
          case (dec_kind)
            XK_FETCH: begin
              mrd_addr_q <= dec_entry;
              state_q    <= ST_FETCH;
            end
            XK_DIRECT: begin
              hit_q   <= 1'b1;
              raddr_q <= dec_base;
              rmask_q <= dec_mask;
              state_q <= ST_RESP;
            end
            default: begin
              hit_q   <= 1'b0;
              raddr_q <= '0;
              rmask_q <= '0;
              state_q <= ST_RESP;
            end
          endcase
        end
        ST_FETCH: if (mrd_ready) state_q <= ST_WAIT;
        ST_WAIT: if (mrd_rvalid) begin
          if (mrd_rdata[0]) begin
            hit_q   <= 1'b1;
            raddr_q <= (mrd_rdata & FRAME_KEEP) << FRAME_SHIFT;
            rmask_q <= PAGE_OFS;
          end else begin
            hit_q   <= 1'b0;
            raddr_q <= '0;
            rmask_q <= '0;
          end
          state_q <= ST_RESP;
        end
        ST_RESP: if (rsp_ready) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready  = (state_q == ST_IDLE);
  assign mrd_valid  = (state_q == ST_FETCH);
  assign mrd_rready = (state_q == ST_WAIT);
  assign mrd_addr   = mrd_addr_q;
  assign rsp_valid  = (state_q == ST_RESP);
  assign rsp_hit    = hit_q;
  assign rsp_addr   = raddr_q;
  assign rsp_mask   = rmask_q;

  assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!rsp_valid && !mrd_valid && !mrd_rready));

  assert_rsp_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_hit)
                                   && $stable(rsp_addr) && $stable(rsp_mask)));

  assert_mrd_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (mrd_valid && !mrd_ready) |=> (mrd_valid && $stable(mrd_addr)));

  assert_single_read_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (mrd_valid && mrd_ready) |=> (!mrd_valid && mrd_rready));

  assert_entry_align_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mrd_valid |-> (mrd_addr[2:0] == 3'b000));

  assert_miss_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_hit) |-> (rsp_addr == '0 && rsp_mask == '0));

  assert_page_frame_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_hit && rsp_mask == PAGE_OFS) |-> (rsp_addr[12:0] == '0));

  assert_latency_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (!rsp_valid && !mrd_valid) ##1 (rsp_valid || mrd_valid));
endmodule

// File: tb/pci_dma_xlate_bench.sv
module pci_dma_xlate_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_sel = '0;
  logic [63:0] cfg_wdata = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [63:0] req_addr = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b0;
  logic        rsp_hit;
  logic [63:0] rsp_addr, rsp_mask;
  logic        mrd_valid;
  logic        mrd_ready = 1'b0;
  logic [63:0] mrd_addr;
  logic        mrd_rvalid = 1'b0;
  logic        mrd_rready;
  logic [63:0] mrd_rdata = '0;

  int n_cmp = 0;
  int n_bad = 0;
  int fetch_cnt = 0;
  logic [63:0] last_fetch = '0;
  bit finished = 1'b0;

  logic [63:0] m_base [4];
  logic [63:0] m_mask [4];
  logic [63:0] m_tba  [4];
  bit          m_hole, m_pass;

  always #2 clk = ~clk;

  pci_dma_xlate u_pci_dma_xlate (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_hit(rsp_hit),
    .rsp_addr(rsp_addr), .rsp_mask(rsp_mask),
    .mrd_valid(mrd_valid), .mrd_ready(mrd_ready), .mrd_addr(mrd_addr),
    .mrd_rvalid(mrd_rvalid), .mrd_rready(mrd_rready), .mrd_rdata(mrd_rdata)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Memory contents: a scrambled word whose valid bit is the inverse of address bit 3
  function automatic logic [63:0] pte_of(input logic [63:0] a);
    logic [63:0] v;
    v = {a[31:0] * 32'h9E37_79B9, a[31:0] ^ 32'h5A5A_1230};
    v[0] = ~a[3];
    return v;
  endfunction

  // R2 field masking as the bench understands it
  task automatic cfg(input logic [1:0] grp, input logic [1:0] idx, input logic [63:0] v);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = {grp, idx}; cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0;
    case (grp)
      2'd0: m_base[idx] = (idx == 2'd3) ? ((v & 64'h80_fff0_0001) | 64'h2) : (v & 64'hfff0_0003);
      2'd1: m_mask[idx] = v & 64'hfff0_0000;
      2'd2: m_tba[idx]  = v & 64'h7_ffff_fc00;
      default: if (idx == 2'd0) begin m_hole = v[5]; m_pass = v[6]; end
    endcase
  endtask

  // kind: 0 miss, 1 direct, 2 table read
  function automatic void model(input logic [63:0] a, output int k,
                                output logic [63:0] rb, output logic [63:0] rm, output logic [63:0] ea);
    logic [63:0] ext;
    k = 0; rb = '0; rm = '0; ea = '0;
    if (a < 64'h1_0000_0000) begin
      if (m_hole && a >= 64'h8_0000 && a <= 64'hf_ffff) return;
      for (int w = 0; w < 4; w++) begin
        if (w == 3 && m_base[3][39]) continue;
        ext = m_mask[w] | 64'hf_ffff;
        if (m_base[w][0] && ((a & ~ext) == (m_base[w] & 64'hfff0_0000))) begin
          if (m_base[w][1]) begin
            k = 2;
            ea = (m_tba[w] & ~(m_mask[w] >> 10)) | ((a & (m_mask[w] | 64'hf_e000)) >> 10);
          end else begin
            k = 1; rb = m_tba[w] & ~ext; rm = ext;
          end
          return;
        end
      end
    end else if (a >= 64'h100_0000_0000 && a < 64'h200_0000_0000) begin
      if (m_pass) begin k = 1; rm = 64'h7_ffff_ffff; end
    end else if (a >= 64'h800_0000_0000 && a < 64'h1000_0000_0000) begin
      if (m_base[3][0] && m_base[3][39]) begin
        k = 2;
        ea = (m_tba[3] & 64'h7_ffc0_0000) | ((a & 64'hffff_e000) >> 10);
      end
    end
  endfunction

  task automatic xact(input logic [63:0] a, input string tag);
    int k, n, stall;
    logic [63:0] rb, rm, ea, pv, h_addr, h_mask;
    logic eh, h_hit;
    model(a, k, rb, rm, ea);
    eh = (k != 0);
    if (k == 2) begin
      pv = pte_of(ea);
      eh = pv[0];
      rb = pv[0] ? ((pv & 64'h3f_fffe) << 12) : 64'h0;
      rm = pv[0] ? 64'h1fff : 64'h0;
    end
    fetch_cnt = 0;
    @(negedge clk);
    chk(req_ready, "R12 ready when idle", {63'b0, req_ready}, 64'h1);
    req_valid = 1'b1; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    chk(!req_ready, "R12 busy after accept", {63'b0, req_ready}, 64'h0);
    n = 0;
    while (!rsp_valid && n < 200) begin
      @(negedge clk);
      n++;
      if (!rsp_valid) chk(!req_ready, "R12 busy in flight", {63'b0, req_ready}, 64'h0);
    end
    if (k == 2) begin
      chk(fetch_cnt == 1, {tag, " one table read"}, 64'(fetch_cnt), 64'd1);
      chk(last_fetch == ea, {tag, " table address"}, last_fetch, ea);
    end else begin
      chk(fetch_cnt == 0, {tag, " no table read"}, 64'(fetch_cnt), 64'd0);
      chk(n == 1, "R13 latency", 64'(n), 64'd1);
    end
    chk(rsp_hit == eh, {tag, " hit"}, {63'b0, rsp_hit}, {63'b0, eh});
    chk(rsp_addr == rb, {tag, " addr"}, rsp_addr, rb);
    chk(rsp_mask == rm, {tag, " mask"}, rsp_mask, rm);
    h_hit = rsp_hit; h_addr = rsp_addr; h_mask = rsp_mask;
    stall = $urandom % 3;
    for (int s = 0; s < stall; s++) begin
      @(negedge clk);
      chk(rsp_valid && rsp_hit == h_hit && rsp_addr == h_addr && rsp_mask == h_mask,
          "R12 result held", rsp_addr, h_addr);
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    chk(!rsp_valid && req_ready, "R12 released", {63'b0, rsp_valid}, 64'h0);
  endtask

  // Memory responder
  initial begin
    forever begin
      @(negedge clk);
      mrd_ready = ($urandom % 3) != 0;
      if (mrd_valid && mrd_ready) begin
        fetch_cnt++;
        last_fetch = mrd_addr;
        @(negedge clk);
        mrd_ready = 1'b0;
        repeat ($urandom % 3) @(negedge clk);
        mrd_rvalid = 1'b1;
        mrd_rdata = pte_of(last_fetch);
        chk(mrd_rready, "R12 waits for data", {63'b0, mrd_rready}, 64'h1);
        @(negedge clk);
        mrd_rvalid = 1'b0;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=%h expected=%h", 64'h0, 64'h1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [63:0] a;
    for (int w = 0; w < 4; w++) begin m_base[w] = '0; m_mask[w] = '0; m_tba[w] = '0; end
    m_base[3] = 64'h2; m_hole = 0; m_pass = 0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(req_ready && !rsp_valid && !mrd_valid && !mrd_rready, "R1 reset outputs",
        {60'b0, req_ready, rsp_valid, mrd_valid, mrd_rready}, 64'h8);
    xact(64'h1234_5678, "R1 disabled windows miss R11");
    xact(64'h0, "R1 zero address miss");

    // R3 R5 direct window 0
    cfg(2'd1, 2'd0, 64'h0ff0_0000);
    cfg(2'd2, 2'd0, 64'h2_0000_0000);
    cfg(2'd0, 2'd0, 64'hffff_ffff_4000_0001);
    xact(64'h4123_4567, "R5 direct hit");
    xact(64'h5000_0000, "R3 outside window");
    xact(64'h3fff_ffff, "R3 below window");
    // R2: upper base bits dropped, table bit stays as written (0)
    cfg(2'd0, 2'd0, 64'hffff_ffff_4000_0005);
    xact(64'h4fff_fff8, "R2 masked base write");

    // R4 overlap: window 2 covers same region, window 0 wins
    cfg(2'd1, 2'd2, 64'h0);
    cfg(2'd2, 2'd2, 64'h3_0000_0000);
    cfg(2'd0, 2'd2, 64'h4010_0001);
    xact(64'h4012_3450, "R4 priority low index");
    cfg(2'd0, 2'd0, 64'h0);
    xact(64'h4012_3450, "R4 next window");

    // R6 R7 table window 1
    cfg(2'd1, 2'd1, 64'h0030_0000);
    cfg(2'd2, 2'd1, 64'h1_2345_6400);
    cfg(2'd0, 2'd1, 64'h8000_0003);
    xact(64'h8012_0000, "R6 table valid entry R7");
    xact(64'h8012_2000, "R7 invalid entry");
    xact(64'h803f_c018, "R6 top of window");

    // R2 last window forced table mode, R4 wide-enable skip
    cfg(2'd2, 2'd3, 64'h4_0000_0000);
    cfg(2'd1, 2'd3, 64'h0);
    cfg(2'd0, 2'd3, 64'hc000_0001);
    xact(64'hc00a_4000, "R2 last window table mode");
    cfg(2'd0, 2'd3, 64'h80_c000_0001);
    xact(64'hc00a_4000, "R4 last window skipped");
    xact(64'h800_0123_4000, "R10 wide table read");
    xact(64'h800_0123_6000, "R10 wide invalid entry");
    xact(64'h1000_0000_0000, "R10 above wide range");
    xact(64'h400_0000_0000, "R10 unmapped wide");
    cfg(2'd0, 2'd3, 64'h80_c000_0000);
    xact(64'h800_0123_4000, "R10 wide disabled");

    // R8 hole
    cfg(2'd2, 2'd1, 64'h5_0000_0000);
    cfg(2'd1, 2'd1, 64'h0);
    cfg(2'd0, 2'd1, 64'h0000_0001);
    cfg(2'd3, 2'd0, 64'h20);
    xact(64'h8_0000, "R8 hole low edge");
    xact(64'hf_ffff, "R8 hole high edge");
    xact(64'h7_ffff, "R8 below hole");
    cfg(2'd3, 2'd0, 64'h0);
    xact(64'h8_0000, "R8 hole off");

    // R9 pass-through
    xact(64'h100_0000_1234, "R9 pass off");
    cfg(2'd3, 2'd0, 64'h40);
    xact(64'h100_0000_1234, "R9 pass on");
    xact(64'h1ff_ffff_ffff, "R9 pass top");
    xact(64'h200_0000_0000, "R9 above pass");

    // Randomized windows and addresses
    for (int r = 0; r < 200; r++) begin
      if (r % 10 == 0) begin
        for (int w = 0; w < 4; w++) begin
          cfg(2'd1, 2'(w), {32'h0, $urandom} & 64'h0ff0_0000);
          cfg(2'd2, 2'(w), {$urandom, $urandom});
          cfg(2'd0, 2'(w), {$urandom, $urandom});
        end
        cfg(2'd3, 2'd0, {32'h0, $urandom});
      end
      case ($urandom % 4)
        0: a = {32'h0, $urandom};
        1: a = 64'h800_0000_0000 | {32'h0, $urandom};
        2: a = 64'h100_0000_0000 | {32'h0, $urandom};
        default: a = (m_base[$urandom % 4] & 64'hfff0_0000) | {44'h0, 20'($urandom)};
      endcase
      xact(a, "R3 R4 R5 R6 R7 R9 R10 random");
    end

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule